// File: doc/BRIEF.md
# Byte-Stepped I2C Bus Master

A bus master for a two-wire serial bus, run by software one byte at a time through five byte-wide registers on a simple write-strobe bus with an address-decoded read path. Software loads the data register, writes a mode word to issue a START or a repeated START, and the engine sends the loaded byte as the address. After each byte and its acknowledge slot the engine raises a pending flag and holds the clock line low. Clearing the flag starts the next byte in the current direction. A mode write with the start bit clear ends the transfer with a STOP.

Both bus lines are open-drain. Each is a pull-low enable output paired with an input that is read back from the wire. The clock half-period comes from one of two base divisors, multiplied by a four-bit prescale. The read-back inputs pass through a synchroniser and an optional three-sample majority filter. The data pull-low can be delayed by up to three clock cycles. An interrupt output reports the pending flag when it is unmasked. Software can poll the bus-busy and last-acknowledge bits, and a flag reports a lost bus.

Top module: `i2c_byte_master`

## Requirements
- R1: Registers sit at offsets 0x00 (control), 0x04 (mode/status), 0x08 (own address), 0x0C (data) and 0x10 (line control). After reset all of them read 0 and both line enables are 0. The own-address register reads back all 8 written bits. Line control reads back only its low 3 bits.
- R2: A write of the mode register with bit 7 = 1, bit 5 = 1 and bit 4 = 1 while the bus is idle produces a START: SDA falls while SCL is released. The data register is then sent MSB first as the address byte, whatever the direction in bits 7:6. Mode bit 5 then reads 1 (busy).
- R3: After the 9th clock of a byte the engine sets control bit 4 (pending) and holds SCL low for as long as it stays set. Writing control with bit 4 = 0 clears the flag and starts the next byte.
- R4: Writing 1 to control bit 4 never sets the flag, and leaves an already-set flag set.
- R5: The irq output equals pending AND control bit 5 (interrupt enable).
- R6: Mode bit 0 holds the acknowledge level sampled in the 9th clock, where 0 = ACK and 1 = NACK. In transmit (mode 11 or the address byte), the data register afterwards holds the byte sampled from the wire.
- R7: In receive (mode 10) the engine releases SDA for 8 clocks and shifts the sampled bits into the data register. In the 9th clock it pulls SDA low if control bit 7 = 1, and releases it (NACK) if bit 7 = 0.
- R8: A mode-register write with bit 7 = 1 and bit 5 = 0 while a byte is held produces a STOP and clears pending. Busy returns to 0 only after SDA has been released with SCL released, and both enables end at 0.
- R9: Each SCL low phase lasts exactly B*(P+1) clock cycles. P is control bits 3:0, and B is DIV_LO when control bit 6 = 0 or DIV_HI when it is 1.
- R10: Line control bits 1:0 (value D) delay every change of the SDA pull-low enable by D clock cycles relative to the SCL falling edge that causes it.
- R11: With line control bit 2 = 1, the engine sees each input line as the majority of its last three synchronised samples. A one-cycle low pulse in every three cycles on the SDA input then changes no sampled bit.
- R12: A released data bit sampled low while transmitting sets mode bit 3, which stays set until the next START clears it.
- R13: A START request while a byte is held produces a repeated START. It clears pending and sends the data register as a new address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register byte offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the register at addr |
| irq | output | 1 | Interrupt request |
| scl_oe | output | 1 | 1 pulls SCL low |
| scl_in | input | 1 | SCL level on the wire |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | SDA level on the wire |

## Verification
The bench builds the block with DIV_LO = 4 and DIV_HI = 8, so a whole byte takes about a hundred cycles. With these values the bench can run both divisor sources and a non-zero prescale, measuring low phases of 4 and 16 cycles. The short periods also leave room to run complete write, repeated-start, read and stop sequences against a behavioural slave. Further runs cover arbitration with a forced-low line, and filtering against periodic glitches combined with a two-cycle output delay.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int DIV_LO = 16,
  parameter int DIV_HI = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [4:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  output logic       scl_oe,
  input  logic       scl_in,
  output logic       sda_oe,
  input  logic       sda_in
);
  localparam int CW = $clog2(DIV_HI * 16) + 1;
  localparam logic [2:0] S_IDLE = 3'd0, S_STA = 3'd1, S_BIT = 3'd2, S_HOLD = 3'd3, S_STP = 3'd4;

  logic       ackgen, src, ie, pend, busy, txen, arb, lastack, hi, addr_ph;
  logic [3:0] pre, bitcnt;
  logic [1:0] mode, ph;
  logic [7:0] oadr, shr;
  logic [2:0] lc, st, dly, sda_h, scl_h;
  logic [1:0] sda_s, scl_s;
  logic [CW-1:0] cnt, half;
  logic       sda_int, scl_int, sda_f, scl_f, active, en, tick, tx;

  function automatic logic maj(input logic [2:0] v);
    return (v[0] & v[1]) | (v[1] & v[2]) | (v[0] & v[2]);
  endfunction

  wire wr_ctl = wr_en && addr == 5'h00;
  wire wr_st  = wr_en && addr == 5'h04;
  wire wr_oa  = wr_en && addr == 5'h08;
  wire wr_ds  = wr_en && addr == 5'h0C;
  wire wr_lc  = wr_en && addr == 5'h10;

  assign sda_f  = lc[2] ? maj(sda_h) : sda_s[1];
  assign scl_f  = lc[2] ? maj(scl_h) : scl_s[1];
  assign tx     = mode[0] | addr_ph;
  assign half   = (src ? CW'(DIV_HI) : CW'(DIV_LO)) * (CW'(pre) + CW'(1));
  assign active = (st == S_STA) || (st == S_BIT) || (st == S_STP);
  assign en     = scl_int | scl_f;
  assign tick   = active && en && (cnt == half - CW'(1));
  assign irq    = pend & ie;
  assign scl_oe = scl_int;
  assign sda_oe = (lc[1:0] == 2'd0) ? sda_int : (lc[1:0] == 2'd1) ? dly[0] :
                  (lc[1:0] == 2'd2) ? dly[1] : dly[2];

  always_comb begin
    scl_int = 1'b0;
    sda_int = 1'b0;
    case (st)
      S_STA:  begin scl_int = (ph == 2'd0) || (ph == 2'd3); sda_int = ph[1]; end
      S_BIT:  begin
        scl_int = !hi;
        sda_int = (bitcnt == 4'd8) ? (!tx && ackgen) : (tx && !shr[7]);
      end
      S_HOLD: scl_int = 1'b1;
      S_STP:  begin scl_int = (ph == 2'd0); sda_int = (ph != 2'd2); end
      default: ;
    endcase
  end

  always_comb begin
    case (addr)
      5'h00:   rdata = {ackgen, src, ie, pend, pre};
      5'h04:   rdata = {mode, busy, txen, arb, 2'b00, lastack};
      5'h08:   rdata = oadr;
      5'h0C:   rdata = shr;
      5'h10:   rdata = {5'b0, lc};
      default: rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sda_s <= '1; scl_s <= '1; sda_h <= '1; scl_h <= '1; dly <= '0; cnt <= '0;
    end else begin
      sda_s <= {sda_s[0], sda_in};
      scl_s <= {scl_s[0], scl_in};
      sda_h <= {sda_h[1:0], sda_s[1]};
      scl_h <= {scl_h[1:0], scl_s[1]};
      dly   <= {dly[1:0], sda_int};
      if (!active || tick) cnt <= '0;
      else if (en)         cnt <= cnt + CW'(1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ackgen <= 0; src <= 0; ie <= 0; pend <= 0; pre <= '0; mode <= '0;
      busy <= 0; txen <= 0; arb <= 0; lastack <= 0; oadr <= '0; shr <= '0;
      lc <= '0; st <= S_IDLE; ph <= '0; bitcnt <= '0; hi <= 0; addr_ph <= 0;
    end else begin
      if (wr_ctl) begin
        ackgen <= wdata[7]; src <= wdata[6]; ie <= wdata[5]; pre <= wdata[3:0];
        if (!wdata[4]) begin
          pend <= 1'b0;
          if (st == S_HOLD) begin st <= S_BIT; bitcnt <= '0; hi <= 1'b0; end
        end
      end
      if (wr_st) begin
        mode <= wdata[7:6];
        txen <= wdata[4];
        if (wdata[7] && wdata[5] && wdata[4] && (st == S_IDLE || st == S_HOLD)) begin
          st <= S_STA; ph <= (st == S_IDLE) ? 2'd1 : 2'd0;
          busy <= 1'b1; arb <= 1'b0; addr_ph <= 1'b1; pend <= 1'b0;
        end else if (wdata[7] && !wdata[5] && st == S_HOLD) begin
          st <= S_STP; ph <= 2'd0; pend <= 1'b0;
        end
      end
      if (wr_oa) oadr <= wdata;
      if (wr_ds) shr <= wdata;
      if (wr_lc) lc <= wdata[2:0];
      if (tick)
        case (st)
          S_STA:
            if (ph == 2'd3) begin st <= S_BIT; bitcnt <= '0; hi <= 1'b0; end
            else ph <= ph + 2'd1;
          S_BIT:
            if (!hi) hi <= 1'b1;
            else begin
              hi <= 1'b0;
              if (bitcnt == 4'd8) begin
                lastack <= sda_f; st <= S_HOLD; pend <= 1'b1; addr_ph <= 1'b0;
              end else begin
                shr <= {shr[6:0], sda_f};
                if (tx && shr[7] && !sda_f) arb <= 1'b1;
                bitcnt <= bitcnt + 4'd1;
              end
            end
          S_STP:
            if (ph == 2'd2) begin st <= S_IDLE; busy <= 1'b0; end
            else ph <= ph + 2'd1;
          default: ;
        endcase
    end
endmodule

// File: rtl/i2c_byte_master_chk.sv
module i2c_byte_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq,
  input logic       scl_oe,
  input logic       pend,
  input logic       busy,
  input logic       lastack,
  input logic       sda_drv,
  input logic [2:0] st
);
  localparam logic [2:0] S_STA = 3'd1, S_BIT = 3'd2, S_STP = 3'd4;

  p_hold_low_r3: assert property (@(posedge clk) disable iff (!rst_n) irq |-> scl_oe);
  p_pend_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(st) == S_BIT);
  p_busy_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(st) == S_STP);
  p_ack_upd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lastack) |-> $past(st) == S_BIT);
  p_sda_still_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && !$stable(sda_drv)) |-> (st == S_STA || st == S_STP));
endmodule

bind i2c_byte_master i2c_byte_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .scl_oe(scl_oe), .pend(pend),
  .busy(busy), .lastack(lastack), .sda_drv(sda_int), .st(st)
);

// File: tb/i2c_byte_master_test.sv
`timescale 1ns/1ps
module i2c_byte_master_test;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [4:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic irq, scl_oe, sda_oe;
  logic s_drv = 0, force_low = 0, glitch = 0, glitch_on = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  wire bus_scl = ~scl_oe;
  wire bus_sda = ~(sda_oe | s_drv);

  always #2.5 clk = ~clk;

  i2c_byte_master #(.DIV_LO(4), .DIV_HI(8)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq), .scl_oe(scl_oe), .scl_in(bus_scl),
    .sda_oe(sda_oe), .sda_in(bus_sda & ~force_low & ~glitch)
  );

  // behavioural slave at address 0x2A and line monitors
  logic p_scl = 1, p_sda = 1, p_scl_oe = 0, p_sda_oe = 0;
  int bitn = 0, starts = 0, stops = 0;
  bit addrph = 0, reading = 0, sending = 0, mslot = 0;
  logic [7:0] rx = 0, txb = 0, next_tx = 8'hA5;
  logic [7:0] rxq[$];
  bit mack[$];
  int run = 0, minlow = 9999, gap = 0, dexp = 0, geq = 0, glt = 0, bad_hold = 0, gcnt = 0;

  always @(negedge clk) begin
    if (glitch_on) begin gcnt = (gcnt == 2) ? 0 : gcnt + 1; glitch = (gcnt == 0); end
    else glitch = 0;
    if (rst_n) begin
      if (p_scl && bus_scl && p_sda && !bus_sda) begin
        starts++; bitn = 0; addrph = 1; reading = 0; sending = 0; s_drv = 0;
      end else if (p_scl && bus_scl && !p_sda && bus_sda) begin
        stops++; s_drv = 0;
      end else if (!p_scl && bus_scl) begin
        if (bitn < 8) rx = {rx[6:0], bus_sda};
        else if (mslot) begin mack.push_back(!bus_sda); sending = !bus_sda; end
        bitn = (bitn == 8) ? 0 : bitn + 1;
      end else if (p_scl && !bus_scl) begin
        if (bitn == 8) begin
          mslot = !addrph && reading;
          if (addrph) begin
            s_drv = (rx[7:1] == 7'h2A); reading = rx[0] && s_drv; sending = reading; addrph = 0;
          end else if (reading) s_drv = 0;
          else begin rxq.push_back(rx); s_drv = (rx != 8'hFF); end
        end else if (bitn == 0) begin
          if (sending) begin txb = next_tx; next_tx = next_tx + 1; s_drv = !txb[7]; end
          else s_drv = 0;
        end else s_drv = sending ? !txb[7-bitn] : 1'b0;
      end
      p_scl = bus_scl; p_sda = bus_sda;
      // per-clock observations
      if (irq && !scl_oe) bad_hold++;
      if (scl_oe) run++;
      else begin if (run > 0 && run < minlow) minlow = run; run = 0; end
      if (scl_oe && !p_scl_oe) gap = 0; else gap++;
      if (sda_oe != p_sda_oe && scl_oe) begin
        if (gap == dexp) geq++; else if (gap < dexp) glt++;
      end
      p_scl_oe = scl_oe; p_sda_oe = sda_oe;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic wait_bit(input logic [4:0] a, input int b, input logic v, input string tag);
    logic [7:0] d;
    for (int i = 0; i < 20000; i++) begin
      rd(a, d);
      if (d[b] == v) return;
    end
    chk(tag, 0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(5'h00, d); chk("R1 ctrl reset", d, 0);
    rd(5'h04, d); chk("R1 status reset", d, 0);
    rd(5'h08, d); chk("R1 own addr reset", d, 0);
    rd(5'h10, d); chk("R1 line ctrl reset", d, 0);
    chk("R1 irq reset", irq, 0);
    chk("R1 line enables reset", {scl_oe, sda_oe}, 0);
    wr(5'h08, 8'h5A); rd(5'h08, d); chk("R1 own addr readback", d, 8'h5A);
    wr(5'h10, 8'hFF); rd(5'h10, d); chk("R1 line ctrl 3 bits", d, 8'h07);
    wr(5'h10, 8'h00);
    // R4 idle write of pending
    wr(5'h00, 8'h30); rd(5'h00, d); chk("R4 idle pend write ignored", d, 8'h20);
    chk("R4 irq stays low", irq, 0);

    // write, repeated start, read, stop
    wr(5'h00, 8'hA0); minlow = 9999; dexp = 0; geq = 0; glt = 0;
    wr(5'h0C, 8'h54); wr(5'h04, 8'hF0);
    rd(5'h04, d); chk("R2 busy after start", d[5], 1);
    wait_bit(5'h00, 4, 1, "R3 pending after address");
    chk("R2 start seen", starts, 1);
    chk("R5 irq with enable", irq, 1);
    chk("R3 scl held low", scl_oe, 1);
    rd(5'h04, d); chk("R6 address ACK", d[0], 0);
    wr(5'h00, 8'hB0); repeat (30) @(negedge clk);
    rd(5'h00, d); chk("R4 pend write 1 keeps flag", d[4], 1);
    chk("R3 still held after write of 1", scl_oe, 1);
    wr(5'h0C, 8'h3C); wr(5'h00, 8'hA0);
    wait_bit(5'h00, 4, 1, "R3 pending after data");
    rd(5'h04, d); chk("R6 data ACK", d[0], 0);
    rd(5'h0C, d); chk("R6 data readback", d, 8'h3C);
    wr(5'h0C, 8'hFF); wr(5'h00, 8'hA0);
    wait_bit(5'h00, 4, 1, "R3 pending after FF");
    rd(5'h04, d); chk("R6 NACK", d[0], 1);
    wr(5'h0C, 8'h55); wr(5'h04, 8'hB0);
    rd(5'h00, d); chk("R13 restart clears pending", d[4], 0);
    wait_bit(5'h00, 4, 1, "R13 pending after restart");
    chk("R13 second start", starts, 2);
    rd(5'h04, d); chk("R13 read address ACK", d[0], 0);
    wr(5'h00, 8'h80);
    wait_bit(5'h00, 4, 1, "R7 pending byte1");
    rd(5'h0C, d); chk("R7 byte1", d, 8'hA5);
    chk("R5 irq masked", irq, 0);
    wr(5'h00, 8'h00);
    wait_bit(5'h00, 4, 1, "R7 pending byte2");
    rd(5'h0C, d); chk("R7 byte2", d, 8'hA6);
    wr(5'h04, 8'h90);
    wait_bit(5'h04, 5, 0, "R8 busy clear");
    chk("R8 stop seen", stops, 1);
    @(negedge clk); chk("R8 lines released", {scl_oe, sda_oe}, 0);
    chk("R7 master acks", mack.size(), 2);
    if (mack.size() == 2) begin
      chk("R7 ACK with bit7 set", mack[0], 1);
      chk("R7 NACK with bit7 clear", mack[1], 0);
    end
    chk("R3 slave byte count", rxq.size(), 2);
    if (rxq.size() == 2) begin
      chk("R3 slave byte0", rxq[0], 8'h3C);
      chk("R3 slave byte1", rxq[1], 8'hFF);
    end
    chk("R9 low phase base0 pre0", minlow, 4);
    chk("R10 zero delay edges", geq > 0, 1);

    // R12 arbitration
    force_low = 1;
    wr(5'h00, 8'hA0); wr(5'h0C, 8'h54); wr(5'h04, 8'hF0);
    wait_bit(5'h00, 4, 1, "R12 pending");
    rd(5'h04, d); chk("R12 arb flag", d[3], 1);
    rd(5'h0C, d); chk("R12 sampled wire", d, 8'h00);
    wr(5'h04, 8'hD0); force_low = 0;
    wait_bit(5'h04, 5, 0, "R12 busy clear");
    rd(5'h04, d); chk("R12 arb sticky", d[3], 1);

    // R10 and R11: delay 2, filter on, periodic glitches
    wr(5'h10, 8'h06); dexp = 2; geq = 0; glt = 0; glitch_on = 1;
    wr(5'h0C, 8'h54); wr(5'h04, 8'hF0);
    wait_bit(5'h00, 4, 1, "R11 pending address");
    rd(5'h04, d); chk("R12 arb cleared by start", d[3], 0);
    rd(5'h0C, d); chk("R11 filtered address", d, 8'h54);
    wr(5'h0C, 8'hFF); wr(5'h00, 8'hA0);
    wait_bit(5'h00, 4, 1, "R11 pending data");
    rd(5'h0C, d); chk("R11 filtered data", d, 8'hFF);
    rd(5'h04, d); chk("R11 no false arb", d[3], 0);
    chk("R11 NACK seen", d[0], 1);
    wr(5'h04, 8'hD0);
    wait_bit(5'h04, 5, 0, "R10 busy clear");
    glitch_on = 0;
    chk("R10 delayed edges", geq > 0, 1);
    chk("R10 no early edges", glt, 0);

    // R9 other source and prescale
    wr(5'h10, 8'h00); wr(5'h00, 8'hE1); minlow = 9999;
    wr(5'h0C, 8'h54); wr(5'h04, 8'hF0);
    wait_bit(5'h00, 4, 1, "R9 pending");
    wr(5'h04, 8'hD0);
    wait_bit(5'h04, 5, 0, "R9 busy clear");
    chk("R9 low phase base1 pre1", minlow, 16);
    chk("R3 never released while pending", bad_hold, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule